// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block takes decoded transport-stream bytes from the error-correction stage and puts them on the output pins, one 188-byte packet after another. Each incoming byte carries a valid flag, a start-of-packet marker and, on the first byte of a packet, the verdict of the error-correction stage on whether the packet could be corrected. A four-entry input queue absorbs the rate difference between the input and the output, and the input ready signal falls while the queue is full.

Two output formats are available. In parallel mode a whole byte appears on the 8-bit data bus for one output-clock period. In serial mode the byte leaves on bit 0 of the bus, most significant bit first, over eight output-clock periods. In both formats the data, enable, sync and error outputs change only while the output clock is low, so a receiver samples them on its rising edge. The output clock runs only while data is being presented. When marking is switched on, a packet flagged as uncorrectable has bit 7 of its second byte forced to 1, which sets the transport-error indicator in the packet header; every other byte passes through unchanged.

Top module: `ts_out_formatter`

## Requirements
- R1: During and right after reset, the data bus, output clock, enable, sync and error outputs are all 0 and input ready is 1.
- R2: The sync output is 1 while the first byte of a packet (the byte that arrived with the start marker, 0x47) is presented, and 0 for every other byte.
- R3: The enable output is 1 exactly while a byte (parallel) or a bit of a byte (serial) is presented; the output clock, sync and error outputs are 0 whenever enable is 0.
- R4: The error output is 1 for every byte of a packet whose start byte arrived with the uncorrectable flag set; the flag is taken only with the start marker, and a change of it on later bytes of the packet is ignored.
- R5: With marking enabled (mark_en = 1), the second byte (index 1) of a flagged packet leaves with bit 7 forced to 1; with marking disabled, or in an unflagged packet, every byte leaves unchanged, and the start byte is never altered.
- R6: With serial_mode = 0, each byte appears on ts_data[7:0] for one output-clock period of two system cycles: one cycle with the clock low, then one with it high.
- R7: With serial_mode = 1, each byte leaves on ts_data[0] most significant bit first over eight output-clock periods of two cycles each, ts_data[7:1] stays 0, and enable, sync and error hold their values for all eight bits.
- R8: The data bus never changes in a cycle in which the output clock is high; the clock rises only one cycle after the data for that period was presented with the clock low.
- R9: The input queue holds FIFO_DEPTH bytes; in_ready is 0 while it is full, and no accepted byte is lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode | input | 1 | 0: parallel byte output, 1: serial bit output on bit 0 |
| mark_en | input | 1 | 1: force bit 7 of the second byte of flagged packets |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input queue can accept a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_uncor | input | 1 | Packet uncorrectable (taken with in_sop) |
| ts_data | output | 8 | Output data bus |
| ts_clk | output | 1 | Output clock, receiver samples on its rising edge |
| ts_den | output | 1 | Output data enable |
| ts_sync | output | 1 | Packet sync pulse |
| ts_uncor | output | 1 | Uncorrectable packet indicator |

## Verification
The bench goes after the second header byte of flagged packets, with marking on and off and with its bit 7 already clear, since a design that marked the wrong index or ignored the enable would corrupt or miss the error bit. Packets whose flag flips after the start byte check that the indicator follows only the start-of-packet value; a design sampling it per byte would drop or raise the error output mid-packet. Serial packets are pushed at full input rate so the queue fills, exposing a design that loses or reorders bytes under backpressure or shifts bits in the wrong order. Every output-clock rising phase is compared with the preceding low phase to catch data changing on the rising edge.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sop;
        logic              uncor;
    } ts_item_t;

endpackage

// File: rtl/ts_byte_fifo.sv
module ts_byte_fifo
    import ts_out_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  ts_item_t push_item,
    input  logic     pop,
    output ts_item_t head,
    output logic     not_empty,
    output logic     not_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        ts_item_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wr;
        logic [PW-1:0]        rd;
        logic [CW-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wr] = push_item;
            d.wr = (q.wr == PW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (pop) begin
            d.rd = (q.rd == PW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head      = q.mem[q.rd];
    assign not_empty = (q.cnt != '0);
    assign not_full  = (q.cnt != CW'(DEPTH));

    // R9: occupancy never exceeds the depth, and nothing is taken from an empty queue
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> q.cnt != '0);
    a_r9_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> q.cnt == $past(q.cnt) + 1'b1);
endmodule

// File: rtl/ts_pkt_marker.sv
module ts_pkt_marker
    import ts_out_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  ts_item_t          item,
    input  logic              mark_en,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sync,
    output logic              out_uncor
);
    localparam int IDXW = $clog2(PKT_LEN + 1);
    localparam logic [IDXW-1:0] IDX_END  = IDXW'(PKT_LEN);
    localparam logic [IDXW-1:0] IDX_HDR2 = IDXW'(1);

    typedef struct packed {
        logic            err;
        logic [IDXW-1:0] idx;
    } mark_st_t;

    mark_st_t q, d;
    logic            cur_err;
    logic [IDXW-1:0] cur_idx;

    always_comb begin
        cur_err = item.sop ? item.uncor : q.err;
        cur_idx = item.sop ? '0 : q.idx;

        out_sync  = item.sop;
        out_uncor = cur_err;
        out_data  = item.data;
        if (mark_en && cur_err && (cur_idx == IDX_HDR2))
            out_data[BYTE_W-1] = 1'b1;

        d = q;
        if (take) begin
            d.err = cur_err;
            d.idx = (cur_idx < IDX_END) ? cur_idx + 1'b1 : cur_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.err <= 1'b0;
            q.idx <= IDX_END;
        end else begin
            q <= d;
        end
    end

    // R5: the start byte of a packet is never altered
    a_r5_sync_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (take && item.sop) |-> out_data == item.data);
    // R4: between start markers the packet flag does not move
    a_r4_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !item.sop) |=> q.err == $past(q.err));
endmodule

// File: rtl/ts_out_shaper.sv
module ts_out_shaper
    import ts_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_mode,
    input  logic              avail,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              sync_in,
    input  logic              uncor_in,
    output logic              take,
    output logic [BYTE_W-1:0] dout,
    output logic              den,
    output logic              psync,
    output logic              uncor,
    output logic              oclk
);
    localparam int BITW = $clog2(BYTE_W);

    typedef struct packed {
        logic              active;
        logic              ser;
        logic [BYTE_W-2:0] rest;
        logic [BITW-1:0]   bitn;
        logic              ocl;
        logic [BYTE_W-1:0] dout;
        logic              den;
        logic              sync;
        logic              uncor;
    } shp_st_t;

    shp_st_t q, d;

    always_comb begin
        d    = q;
        take = 1'b0;
        if (q.active && !q.ocl) begin
            d.ocl = 1'b1;
        end else if (q.active && q.ser && (q.bitn != '0)) begin
            d.ocl  = 1'b0;
            d.bitn = q.bitn - 1'b1;
            d.dout = {{(BYTE_W-1){1'b0}}, q.rest[BYTE_W-2]};
            d.rest = {q.rest[BYTE_W-3:0], 1'b0};
        end else if (avail) begin
            take     = 1'b1;
            d.active = 1'b1;
            d.ser    = serial_mode;
            d.ocl    = 1'b0;
            d.rest   = byte_in[BYTE_W-2:0];
            d.bitn   = BITW'(BYTE_W - 1);
            d.dout   = serial_mode ? {{(BYTE_W-1){1'b0}}, byte_in[BYTE_W-1]} : byte_in;
            d.den    = 1'b1;
            d.sync   = sync_in;
            d.uncor  = uncor_in;
        end else begin
            d.active = 1'b0;
            d.ocl    = 1'b0;
            d.dout   = '0;
            d.den    = 1'b0;
            d.sync   = 1'b0;
            d.uncor  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.dout;
    assign den   = q.den;
    assign psync = q.sync;
    assign uncor = q.uncor;
    assign oclk  = q.ocl;

    // R8: a low clock phase with data is always followed by a rising phase
    a_r8_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (q.den && !q.ocl) |=> q.ocl);
    // R8: data holds while the clock rises
    a_r8_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ocl) |-> $stable(q.dout));
    // R3: clock, sync and error only with enable
    a_r3_clock_needs_den: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ocl || q.sync || q.uncor) |-> q.den);
    // R7: in serial mode enable, sync and error hold across the bits of a byte
    a_r7_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.ser && q.ocl && q.bitn != '0) |=>
            (q.den && $stable(q.sync) && $stable(q.uncor)));
endmodule

// File: rtl/ts_out_formatter.sv
module ts_out_formatter
    import ts_out_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int PKT_LEN    = 188
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       serial_mode,
    input  logic       mark_en,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_uncor,
    output logic [7:0] ts_data,
    output logic       ts_clk,
    output logic       ts_den,
    output logic       ts_sync,
    output logic       ts_uncor
);
    ts_item_t          push_item;
    ts_item_t          head;
    logic              not_empty;
    logic              not_full;
    logic              take;
    logic [BYTE_W-1:0] mk_data;
    logic              mk_sync;
    logic              mk_uncor;

    assign push_item = '{data: in_data, sop: in_sop, uncor: in_uncor};
    assign in_ready  = not_full;

    ts_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid && not_full),
        .push_item (push_item),
        .pop       (take),
        .head      (head),
        .not_empty (not_empty),
        .not_full  (not_full)
    );

    ts_pkt_marker #(.PKT_LEN(PKT_LEN)) u_marker (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .item      (head),
        .mark_en   (mark_en),
        .out_data  (mk_data),
        .out_sync  (mk_sync),
        .out_uncor (mk_uncor)
    );

    ts_out_shaper u_shaper (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_mode (serial_mode),
        .avail       (not_empty),
        .byte_in     (mk_data),
        .sync_in     (mk_sync),
        .uncor_in    (mk_uncor),
        .take        (take),
        .dout        (ts_data),
        .den         (ts_den),
        .psync       (ts_sync),
        .uncor       (ts_uncor),
        .oclk        (ts_clk)
    );

    // R1: first cycle after reset is idle
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ts_den && !ts_clk && !ts_sync && !ts_uncor && ts_data == '0));
endmodule

// File: tb/ts_out_formatter_test.sv
module ts_out_formatter_test;
    localparam int CLK_PERIOD = 10;
    localparam int PKT        = 188;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_mode = 1'b0;
    logic       mark_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_uncor = 1'b0;
    logic [7:0] ts_data;
    logic       ts_clk;
    logic       ts_den;
    logic       ts_sync;
    logic       ts_uncor;

    int checks = 0;
    int errors = 0;
    bit ready_low_seen = 0;

    typedef struct {
        logic [7:0] data;
        logic       sync;
        logic       uncor;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_out_formatter uut (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .mark_en(mark_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_uncor(in_uncor), .ts_data(ts_data), .ts_clk(ts_clk),
        .ts_den(ts_den), .ts_sync(ts_sync), .ts_uncor(ts_uncor)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return (i == 0) ? 8'h47 : 8'((seed + i * 37) ^ (i >> 3));
    endfunction

    // Driver: pushes one packet and records expected output items
    task automatic send_packet(input int seed, input bit flag_sop, input bit flag_rest);
        for (int i = 0; i < PKT; i++) begin
            exp_t e;
            logic [7:0] b = pat(seed, i);
            e.data  = b;
            e.sync  = (i == 0);
            e.uncor = flag_sop;
            e.tag   = serial_mode ? "R7" : "R6";
            if (i == 1 && flag_sop && mark_en) begin
                e.data = b | 8'h80;
                e.tag  = "R5";
            end
            exp_q.push_back(e);
            in_valid = 1'b1;
            in_data  = b;
            in_sop   = (i == 0);
            in_uncor = (i == 0) ? flag_sop : flag_rest;
            forever begin
                bit ok = in_ready;
                if (!ok) ready_low_seen = 1;
                @(negedge clk);
                if (ok) break;
            end
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_uncor = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        chk(!ts_den && !ts_clk && !ts_sync && !ts_uncor, "R3 idle outputs",
            {ts_den, ts_clk, ts_sync, ts_uncor}, 0);
    endtask

    task automatic compare_unit(input logic [7:0] d, input logic s, input logic u);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(0, "R9 unexpected byte", d, 0);
            return;
        end
        e = exp_q.pop_front();
        chk(d == e.data, e.tag, d, e.data);
        chk(s == e.sync, "R2 sync", s, e.sync);
        chk(u == e.uncor, "R4 uncor", u, e.uncor);
    endtask

    // Monitor: samples away from the active edge
    initial begin
        int nbits = 0;
        logic [7:0] acc = '0;
        logic s0 = 0;
        logic u0 = 0;
        logic [7:0] prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n && ts_clk) begin
                chk(ts_data == prev, "R8 data stable on rise", ts_data, prev);
                chk(ts_den, "R3 den with clock", ts_den, 1);
                if (!serial_mode) begin
                    compare_unit(ts_data, ts_sync, ts_uncor);
                end else begin
                    chk(ts_data[7:1] == 0, "R7 upper bits", ts_data, ts_data & 8'h01);
                    if (nbits == 0) begin
                        s0 = ts_sync;
                        u0 = ts_uncor;
                    end else begin
                        chk(ts_sync == s0 && ts_uncor == u0, "R7 hold",
                            {ts_sync, ts_uncor}, {s0, u0});
                    end
                    acc = {acc[6:0], ts_data[0]};
                    nbits++;
                    if (nbits == 8) begin
                        compare_unit(acc, s0, u0);
                        nbits = 0;
                    end
                end
            end
            prev = ts_data;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!ts_den && !ts_clk && !ts_sync && !ts_uncor && ts_data == 0, "R1 outputs",
            {ts_den, ts_clk, ts_sync, ts_uncor}, 0);
        chk(in_ready, "R1 ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ts_den && !ts_clk && ts_data == 0, "R1 after release", ts_den, 0);

        // Parallel mode, marking on
        serial_mode = 1'b0;
        mark_en     = 1'b1;
        send_packet(3, 1'b0, 1'b0);   // clean
        send_packet(2, 1'b1, 1'b1);   // flagged (byte 1 has bit 7 clear)
        send_packet(90, 1'b0, 1'b1);  // R4: flag appears mid-packet, ignored
        send_packet(5, 1'b1, 1'b0);   // R4: flag drops mid-packet, held
        drain();
        chk(ready_low_seen, "R9 ready low when full", ready_low_seen, 1);

        // Marking off: indicator still raised, data untouched
        mark_en = 1'b0;
        send_packet(2, 1'b1, 1'b1);
        drain();

        // Serial mode
        ready_low_seen = 0;
        serial_mode = 1'b1;
        mark_en     = 1'b1;
        send_packet(11, 1'b1, 1'b0);
        send_packet(4, 1'b0, 1'b0);
        drain();
        chk(ready_low_seen, "R9 ready low in serial", ready_low_seen, 1);

        chk(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule